// File: doc/BRIEF.md
# Phase Current Balance Calculator

This block evens out the current that each leg of a multi-phase switching converter carries. In every switching cycle each active phase delivers one sampled current word together with a valid strobe. After every active phase has reported, the block closes the round. It divides the total of the latest samples by the number of active phases, and that quotient serves both as the load-demand figure and as the reference for balance.

Each phase's deviation from the average goes through a first-order low-pass filter. The filtered deviation is then taken away from one shared compare value, which gives that phase its own compare value for the PWM sequencer. A phase that carries more than its share therefore gets a lower compare value and a shorter pulse. The number of active phases can be two, three or four. A change in that number throws away the filter history and the half-gathered round.

Top module: `phase_balance`

## Requirements
- R1: After reset, `avg_o` is 0 and every filter state is 0, so each `cmp_o` lane equals `cmp_i` clamped to RAMP_MAX.
- R2: A round closes in the cycle after every active phase holds a pending sample. On that clock edge `avg_o` becomes floor(sum of the pending samples / active count). At all other times `avg_o` holds its value.
- R3: `n_act_i` equal to 2 or 3 selects that many phases. Every other value selects 4. Phases 0 to n-1 are active. Strobes on inactive lanes are ignored and do not enter the average.
- R4: When a round closes, each active phase p forms e = sample_p - average. Its filter updates as y += (e - y) >>> K, where the shift is arithmetic and rounds toward minus infinity. The result saturates to a signed W+1 bit range.
- R5: Lane p of `cmp_o` (bits p*CW upward) is cmp_i - y_p clamped to the range 0 to RAMP_MAX. It follows `cmp_i` in the same cycle.
- R6: A second strobe on a phase before its round closes replaces the earlier sample.
- R7: A strobe that arrives in the cycle a round closes is kept and counts toward the next round.
- R8: In a cycle where the effective active count differs from the current one, all filter states and pending samples are cleared, strobes in that cycle are dropped and no round closes.
- R9: Lanes of inactive phases output `cmp_i` clamped to RAMP_MAX, because their filter states stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | 4*W | Sample words, phase p in bits p*W upward |
| samp_vld_i | input | 4 | Per-phase sample strobes |
| n_act_i | input | 3 | Requested active phase count |
| cmp_i | input | CW | Shared compare value |
| cmp_o | output | 4*CW | Per-phase corrected compare values |
| avg_o | output | W | Average current over active phases |

## Verification
Two events can fall on the same cycle: a round closing, and fresh samples arriving for the next round. The bench provokes this by strobing both phases again in the exact cycle a round closes. It then expects the first average from the old pair and, one clock later, a second average from the new pair. A behavioural model that keeps pending flags and filter values as integers is compared with the outputs on every clock, including during random strobe patterns. That comparison also covers the second overlap, where a change in active count coincides with strobes that must be discarded.

// File: rtl/phase_balance.sv
module phase_balance #(
  parameter int W        = 10,
  parameter int CW       = 10,
  parameter int RAMP_MAX = 900,
  parameter int K        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4*W-1:0]  samp_i,
  input  logic [3:0]      samp_vld_i,
  input  logic [2:0]      n_act_i,
  input  logic [CW-1:0]   cmp_i,
  output logic [4*CW-1:0] cmp_o,
  output logic [W-1:0]    avg_o
);
  localparam int NP    = 4;
  localparam int SW    = W + 2;
  localparam int FW    = W + 1;
  localparam int SH    = W + 4;
  localparam int PW    = SW + SH;
  localparam int RECIP = ((1 << SH) + 2) / 3;
  localparam int XW    = ((CW > W) ? CW : W) + 3;
  localparam logic signed [W+1:0] FMAX = {2'b00, {W{1'b1}}};
  localparam logic signed [W+1:0] FMIN = {2'b11, {W{1'b0}}};
  localparam logic signed [XW-1:0] RMAX = XW'(RAMP_MAX);

  logic [2:0]             n_q, n_in;
  logic [NP-1:0]          act_q, got_q, vld;
  logic [W-1:0]           samp_q [NP];
  logic signed [FW-1:0]   filt_q [NP];
  logic signed [FW-1:0]   filt_nx [NP];
  logic signed [W+1:0]    e [NP];
  logic signed [W+1:0]    d [NP];
  logic signed [W+1:0]    t [NP];
  logic signed [XW-1:0]   c [NP];
  logic [SW-1:0]          sum;
  logic [PW-1:0]          prod;
  logic [W-1:0]           avg_c;
  logic                   chg, done;
  logic [NP*FW-1:0]       filt_flat;

  assign n_in  = (n_act_i == 3'd2) ? 3'd2 : (n_act_i == 3'd3) ? 3'd3 : 3'd4;
  assign act_q = (n_q == 3'd2) ? 4'b0011 : (n_q == 3'd3) ? 4'b0111 : 4'b1111;
  assign chg   = (n_in != n_q);
  assign done  = !chg && ((got_q & act_q) == act_q);
  assign vld   = samp_vld_i & act_q;

  always_comb begin
    sum = '0;
    for (int p = 0; p < NP; p++)
      if (act_q[p]) sum = sum + SW'(samp_q[p]);
    prod = PW'(sum) * PW'(RECIP);
    case (n_q)
      3'd2:    avg_c = W'(sum >> 1);
      3'd3:    avg_c = W'(prod >> SH);
      default: avg_c = W'(sum >> 2);
    endcase
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      e[p] = $signed({2'b00, samp_q[p]}) - $signed({2'b00, avg_c});
      d[p] = e[p] - (W+2)'(filt_q[p]);
      t[p] = (W+2)'(filt_q[p]) + (d[p] >>> K);
      if (t[p] > FMAX)      filt_nx[p] = FW'(FMAX);
      else if (t[p] < FMIN) filt_nx[p] = FW'(FMIN);
      else                  filt_nx[p] = FW'(t[p]);
      c[p] = $signed({{(XW-CW){1'b0}}, cmp_i}) - XW'(filt_q[p]);
      if (c[p] < 0)          cmp_o[p*CW +: CW] = '0;
      else if (c[p] > RMAX)  cmp_o[p*CW +: CW] = CW'(RMAX);
      else                   cmp_o[p*CW +: CW] = CW'(c[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= 3'd4;
      got_q <= '0;
      avg_o <= '0;
      for (int p = 0; p < NP; p++) begin
        samp_q[p] <= '0;
        filt_q[p] <= '0;
      end
    end else if (chg) begin
      n_q   <= n_in;
      got_q <= '0;
      for (int p = 0; p < NP; p++) filt_q[p] <= '0;
    end else begin
      got_q <= (done ? '0 : got_q) | vld;
      for (int p = 0; p < NP; p++) begin
        if (vld[p]) samp_q[p] <= samp_i[p*W +: W];
        if (done && act_q[p]) filt_q[p] <= filt_nx[p];
      end
      if (done) avg_o <= avg_c;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_flat
    assign filt_flat[p*FW +: FW] = filt_q[p];
  end
endmodule

// File: rtl/phase_balance_chk.sv
module phase_balance_chk #(
  parameter int W        = 10,
  parameter int CW       = 10,
  parameter int RAMP_MAX = 900
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                chg,
  input logic [2:0]          n_q,
  input logic [3:0]          got_q,
  input logic [4*(W+1)-1:0]  filt_flat,
  input logic [4*CW-1:0]     cmp_o,
  input logic [W-1:0]        avg_o
);
  a_r2_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(avg_o));

  a_r8_count_flush: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (filt_flat == '0) && (got_q == '0));

  a_r3_inactive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q >> n_q) == 4'b0000);

  for (genvar p = 0; p < 4; p++) begin : g_lane
    a_r5_cmp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_o[p*CW +: CW] <= CW'(RAMP_MAX));
    a_r9_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (n_q <= 3'(p)) |-> (filt_flat[p*(W+1) +: (W+1)] == '0));
  end
endmodule

bind phase_balance phase_balance_chk #(.W(W), .CW(CW), .RAMP_MAX(RAMP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .chg(chg), .n_q(n_q), .got_q(got_q),
  .filt_flat(filt_flat), .cmp_o(cmp_o), .avg_o(avg_o));

// File: tb/tb_phase_balance.sv
`timescale 1ns/1ps
module tb_phase_balance;
  localparam int W = 10, CW = 10, RMAX = 900, K = 2;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [4*W-1:0]  samp = '0;
  logic [3:0]      vld = '0;
  logic [2:0]      nact = 3'd4;
  logic [CW-1:0]   cmp = 10'd500;
  logic [4*CW-1:0] cmp_o;
  logic [W-1:0]    avg_o;

  phase_balance #(.W(W), .CW(CW), .RAMP_MAX(RMAX), .K(K)) dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .samp_vld_i(vld), .n_act_i(nact),
    .cmp_i(cmp), .cmp_o(cmp_o), .avg_o(avg_o));

  int errs = 0, checks = 0;
  bit fin = 0;
  string tag = "R1";
  int m_samp[4], m_filt[4], m_got[4];
  int m_n = 4, m_avg = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 4; m_avg = 0;
      for (int p = 0; p < 4; p++) begin m_samp[p] = 0; m_filt[p] = 0; m_got[p] = 0; end
    end else begin
      int nin;
      nin = (nact == 2) ? 2 : (nact == 3) ? 3 : 4;
      if (nin != m_n) begin
        m_n = nin;
        for (int p = 0; p < 4; p++) begin m_filt[p] = 0; m_got[p] = 0; end
      end else begin
        bit all;
        all = 1;
        for (int p = 0; p < m_n; p++) if (!m_got[p]) all = 0;
        if (all) begin
          int s;
          s = 0;
          for (int p = 0; p < m_n; p++) s += m_samp[p];
          m_avg = s / m_n;
          for (int p = 0; p < m_n; p++) begin
            int ev;
            ev = m_samp[p] - m_avg;
            m_filt[p] = m_filt[p] + ((ev - m_filt[p]) >>> K);
            if (m_filt[p] > (1 << W) - 1) m_filt[p] = (1 << W) - 1;
            if (m_filt[p] < -(1 << W)) m_filt[p] = -(1 << W);
            m_got[p] = 0;
          end
        end
        for (int p = 0; p < m_n; p++)
          if (vld[p]) begin m_samp[p] = int'(samp[p*W +: W]); m_got[p] = 1; end
      end
    end
  end

  function automatic int exp_cmp(int p);
    int v;
    v = int'(cmp) - m_filt[p];
    if (v < 0) v = 0;
    if (v > RMAX) v = RMAX;
    return v;
  endfunction

  function automatic int lane(int p);
    return int'(cmp_o[p*CW +: CW]);
  endfunction

  task automatic tick();
    logic [4*CW-1:0] ev;
    @(negedge clk);
    for (int p = 0; p < 4; p++) ev[p*CW +: CW] = CW'(exp_cmp(p));
    checks++;
    if (avg_o != W'(m_avg) || cmp_o != ev) begin
      errs++;
      $display("FAIL %s model: avg=%0d exp %0d cmp=%h exp %h", tag, avg_o, m_avg, cmp_o, ev);
    end
  endtask

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic put(int p, int v);
    vld[p] = 1'b1;
    samp[p*W +: W] = W'(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 avg", int'(avg_o), 0);
    chk("R1 lane0", lane(0), 500);
    chk("R1 lane3", lane(3), 500);
    cmp = 10'd1000;
    tick();
    chk("R5 upper clamp", lane(0), 900);
    cmp = 10'd500;

    tag = "R2";
    put(0, 100); put(1, 200); put(2, 300); put(3, 400);
    tick(); vld = '0;
    chk("R2 hold before close", int'(avg_o), 0);
    tick();
    chk("R2 avg of four", int'(avg_o), 250);
    chk("R4 lane0", lane(0), 538);
    chk("R4 lane1", lane(1), 513);
    chk("R4 lane2", lane(2), 488);
    chk("R4 lane3", lane(3), 463);
    cmp = 10'd10;
    tick();
    chk("R5 lower clamp", lane(3), 0);
    chk("R5 lane0 low cmp", lane(0), 48);
    cmp = 10'd500;

    tag = "R8";
    nact = 3'd2; put(0, 900); put(1, 900);
    tick(); vld = '0;
    chk("R8 filters cleared lane0", lane(0), 500);
    chk("R8 filters cleared lane3", lane(3), 500);
    put(1, 50);
    tick(); vld = '0;
    tick();
    chk("R8 dropped strobes keep round open", int'(avg_o), 250);

    tag = "R6";
    put(1, 80);
    tick(); vld = '0;
    put(0, 700);
    tick(); vld = '0;
    tick();
    chk("R6 replaced sample", int'(avg_o), 390);
    chk("R4 lane0 two phase", lane(0), 423);
    chk("R4 lane1 two phase", lane(1), 578);
    chk("R9 inactive lane2", lane(2), 500);
    chk("R9 inactive lane3", lane(3), 500);

    tag = "R7";
    put(0, 200); put(1, 400);
    tick();
    put(0, 10); put(1, 30);
    tick(); vld = '0;
    chk("R7 first round", int'(avg_o), 300);
    tick();
    chk("R7 carried round", int'(avg_o), 20);

    tag = "R3";
    nact = 3'd3;
    tick();
    put(0, 100); put(1, 100); put(2, 101); put(3, 1000);
    tick(); vld = '0;
    tick();
    chk("R3 divide by three, lane3 ignored", int'(avg_o), 100);
    put(0, 1023); put(1, 1023); put(2, 1022);
    tick(); vld = '0;
    tick();
    chk("R3 divide by three top", int'(avg_o), 1022);
    nact = 3'd5;
    tick();
    put(0, 4); put(1, 4); put(2, 4); put(3, 8);
    tick(); vld = '0;
    tick();
    chk("R3 other code selects four", int'(avg_o), 5);

    tag = "R4";
    for (int i = 0; i < 600; i++) begin
      vld = 4'($urandom_range(0, 15));
      samp = 40'({$urandom, $urandom});
      cmp = 10'($urandom_range(0, 1023));
      if ($urandom_range(0, 40) == 0) nact = 3'($urandom_range(0, 7));
      tick();
    end
    vld = '0;
    tick();

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule